// File: doc/BRIEF.md
# Per-CPU Interrupt Enable Controller

This block collects a set of level-sensitive interrupt sources, 32 for each source word, and presents one interrupt line to each of several processors. Every processor owns a private register bank that holds one read/write enable word for each source word, followed by read-only status words. The status words show the synchronized source levels. A processor's interrupt line goes high when at least one source is active and enabled in that processor's bank.

Software reaches the banks through a plain memory-mapped port. The port takes a byte address, a write strobe and write data, and returns read data combinationally. Registers are 32-bit words on 4-byte boundaries, and the two low address bits are ignored. Inside each register group, the word order is reversed: the lowest address holds the highest-numbered sources.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every enable word reads 0 and every interrupt output is low.
- R2: A write to an enable word replaces all 32 bits at once, and a read of that word returns the last value written.
- R3: Bank slots 0..N_WORDS-1 are enable words. Slot s holds the enables of sources 32*(N_WORDS-1-s) to 32*(N_WORDS-1-s)+31, with bit b of the word controlling source 32*(N_WORDS-1-s)+b. With two words, byte offset 0 covers sources 32-63 and offset 4 covers sources 0-31.
- R4: Bank slots N_WORDS..2*N_WORDS-1 are status words and use the same reversed order. With two words, offset 8 shows sources 32-63 and offset 12 shows sources 0-31. Status reflects the source levels whatever the enables hold.
- R5: Each bank spans 8*N_WORDS bytes, and bank c starts at byte address c*8*N_WORDS. With two words, the second processor's bank starts at 0x10.
- R6: Interrupt output c is registered. It equals the OR over all sources of (status AND bank c enable), one clock after the status or enable value it depends on changes.
- R7: Each source passes through two flip-flops. A level change applied before clock edge e1 appears in the status words after edge e2, and on an interrupt output after edge e3.
- R8: Writes to status words and to addresses at or beyond N_CPUS*8*N_WORDS change no enable bit. Reads of such undecoded addresses return 0.
- R9: The enables of one processor have no effect on the interrupt output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32*N_WORDS | Level-sensitive interrupt sources |
| addr_i | input | ADDR_W | Byte address of the register port |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| cpu_irq_o | output | N_CPUS | One interrupt line per processor |

## Verification
On every cycle, the assertions check four things. An all-zero enable bank keeps its line low. A write strobe lands exactly in the addressed word, and no other cycle disturbs the enables. A rising interrupt always has an enabled, active source behind it. The synchronizer delays its input by exactly two edges. The bench scenarios are needed for the rest: the reversed word order, the bank placement, status versus enable separation, the undecoded reads, the exact edge on which an output follows a source or enable change, and the independence of the processors.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_EN   = 2'd1,
        REG_STAT = 2'd2
    } reg_kind_e;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

    // R7: output is the input of two edges earlier once reset has been released for two edges
    assert_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/irqf_decode.sv
module irqf_decode
    import irqf_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned N_CPUS  = 2,
    parameter int unsigned WA_W    = 6,
    parameter int unsigned CPU_W   = 1,
    parameter int unsigned WIDX_W  = 1
) (
    input  logic [WA_W-1:0]   word_addr_i,
    output reg_kind_e         kind_o,
    output logic [CPU_W-1:0]  cpu_o,
    output logic [WIDX_W-1:0] word_o
);
    localparam int unsigned SLOTS  = 2 * N_WORDS;
    localparam int unsigned LIMIT  = N_CPUS * SLOTS;

    logic [31:0] wa;
    logic [31:0] slot;
    logic [31:0] bank;

    always_comb begin
        wa     = 32'(word_addr_i);
        bank   = wa / SLOTS;
        slot   = wa % SLOTS;
        kind_o = REG_NONE;
        cpu_o  = CPU_W'(bank);
        word_o = '0;
        if (wa < LIMIT) begin
            if (slot < N_WORDS) begin
                kind_o = REG_EN;
                word_o = WIDX_W'(N_WORDS - 1 - slot);
            end else begin
                kind_o = REG_STAT;
                word_o = WIDX_W'(SLOTS - 1 - slot);
            end
        end
    end
endmodule

// File: rtl/irqf_bank.sv
module irqf_bank
    import irqf_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned WIDX_W  = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [WIDX_W-1:0]           wr_idx_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    input  logic [N_WORDS*WORD_W-1:0]   status_i,
    output logic [N_WORDS*WORD_W-1:0]   en_o,
    output logic                        irq_o
);
    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] en;
        logic                           irq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (wr_en_i) st_d.en[wr_idx_i] = wr_data_i;
        st_d.irq = |(st_q.en & status_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign irq_o = st_q.irq;

    // R1: a bank with nothing enabled cannot raise its line
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |=> !irq_o);

    // R2: a strobed write lands whole in the addressed word
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.en[$past(wr_idx_i)] == $past(wr_data_i)));

    // R8: without a strobe for this bank the enables hold
    assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.en));

    // R6: a rising line always has an enabled, active source behind it
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(en_o & status_i)));
endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl
    import irqf_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned N_CPUS  = 2,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [32*N_WORDS-1:0]       src_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_en_i,
    input  logic [31:0]                 wr_data_i,
    output logic [31:0]                 rd_data_o,
    output logic [N_CPUS-1:0]           cpu_irq_o
);
    localparam int unsigned N_SRC  = WORD_W * N_WORDS;
    localparam int unsigned WA_W   = ADDR_W - 2;
    localparam int unsigned CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1;
    localparam int unsigned WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic                            unused_lsb;
    logic [N_SRC-1:0]                status;
    reg_kind_e                       dec_kind;
    logic [CPU_W-1:0]                dec_cpu;
    logic [WIDX_W-1:0]               dec_word;
    logic [N_CPUS-1:0][N_SRC-1:0]    en_all;

    assign unused_lsb = ^addr_i[1:0];

    irqf_sync #(.W(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (status)
    );

    irqf_decode #(
        .N_WORDS (N_WORDS),
        .N_CPUS  (N_CPUS),
        .WA_W    (WA_W),
        .CPU_W   (CPU_W),
        .WIDX_W  (WIDX_W)
    ) u_decode (
        .word_addr_i (addr_i[ADDR_W-1:2]),
        .kind_o      (dec_kind),
        .cpu_o       (dec_cpu),
        .word_o      (dec_word)
    );

    for (genvar c = 0; c < N_CPUS; c++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en_i && (dec_kind == REG_EN) && (dec_cpu == CPU_W'(c));

        irqf_bank #(
            .N_WORDS (N_WORDS),
            .WIDX_W  (WIDX_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (bank_wr),
            .wr_idx_i  (dec_word),
            .wr_data_i (wr_data_i),
            .status_i  (status),
            .en_o      (en_all[c]),
            .irq_o     (cpu_irq_o[c])
        );
    end

    always_comb begin
        rd_data_o = '0;
        case (dec_kind)
            REG_EN:   rd_data_o = en_all[dec_cpu][dec_word*WORD_W +: WORD_W];
            REG_STAT: rd_data_o = status[dec_word*WORD_W +: WORD_W];
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: tb/irq_fanout_ctrl_bench.sv
module irq_fanout_ctrl_bench;
    localparam int unsigned N_WORDS = 2;
    localparam int unsigned N_CPUS  = 2;
    localparam int unsigned ADDR_W  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [32*N_WORDS-1:0] src_i = '0;
    logic [ADDR_W-1:0]     addr_i = '0;
    logic                  wr_en_i = 1'b0;
    logic [31:0]           wr_data_i = '0;
    logic [31:0]           rd_data_o;
    logic [N_CPUS-1:0]     cpu_irq_o;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    irq_fanout_ctrl #(.N_WORDS(N_WORDS), .N_CPUS(N_CPUS), .ADDR_W(ADDR_W)) u_irq_fanout_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .cpu_irq_o (cpu_irq_o)
    );

    // driver tasks: called at a falling edge, return at the next falling edge
    task automatic put_rd(input logic [7:0] a, input logic [31:0] e, input string r);
        item_t it;
        addr_i = a;
        it.is_irq = 0; it.exp = e; it.req = r;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic put_irq(input logic [31:0] e, input string r);
        item_t it;
        it.is_irq = 1; it.exp = e; it.req = r;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // monitor: compares one expected item shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? 32'(cpu_irq_o) : rd_data_o;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s %s: actual=%h expected=%h", it.req,
                             it.is_irq ? "irq" : "read", act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        put_rd(8'h00, 32'h0, "R1");
        put_rd(8'h14, 32'h0, "R1");
        put_irq(32'h0, "R1");

        // R2 full-word replace and read back
        wr(8'h04, 32'hA5A5_0F0F);
        put_rd(8'h04, 32'hA5A5_0F0F, "R2");
        wr(8'h04, 32'h0000_0001);
        put_rd(8'h04, 32'h0000_0001, "R2");

        // R7 two-stage delay, R4 status placement (source 40 = word1 bit8)
        src_i = 64'h1 << 40;
        put_rd(8'h08, 32'h0, "R7");
        put_rd(8'h08, 32'h0000_0100, "R7");
        put_rd(8'h0C, 32'h0, "R4");
        put_irq(32'h0, "R4");

        // R3 reversed enable order: offset 4 is sources 0-31, no effect on source 40
        wr(8'h04, 32'h0000_0100);
        put_irq(32'h0, "R3");
        wr(8'h00, 32'h0000_0100);
        put_irq(32'h1, "R6");   // R9: second processor stays low

        // R5 second bank at 0x10
        put_rd(8'h18, 32'h0000_0100, "R5");
        wr(8'h10, 32'h0000_0100);
        put_irq(32'h3, "R5");

        // R8 status and undecoded writes ignored
        wr(8'h08, 32'hFFFF_FFFF);
        put_rd(8'h08, 32'h0000_0100, "R8");
        put_rd(8'h00, 32'h0000_0100, "R8");
        put_rd(8'h04, 32'h0000_0100, "R8");
        wr(8'h24, 32'hFFFF_FFFF);
        put_rd(8'h20, 32'h0, "R8");
        put_rd(8'h14, 32'h0, "R8");
        put_rd(8'h10, 32'h0000_0100, "R8");

        // R9 clearing the second bank leaves the first line up
        wr(8'h10, 32'h0);
        put_irq(32'h1, "R9");

        // R6/R7 source drop reaches the line after the third edge
        src_i = '0;
        put_irq(32'h1, "R7");
        put_irq(32'h1, "R7");
        put_irq(32'h0, "R6");

        // R6 OR across words: source 8 with offset 4 bit8 enabled
        src_i = 64'h1 << 8;
        put_irq(32'h0, "R7");
        put_irq(32'h0, "R7");
        put_irq(32'h1, "R6");
        put_rd(8'h0C, 32'h0000_0100, "R4");
        put_rd(8'h1C, 32'h0000_0100, "R4");

        // R6 enable removal seen one edge later
        wr(8'h04, 32'h0);
        put_irq(32'h0, "R6");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule